// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is a two-wire serial bus target that runs from a fast internal clock. It samples the open-drain clock and data lines through synchronizer flops and finds bus conditions from the synchronized levels. A falling data line while the clock is high opens a transfer; a rising data line while the clock is high closes it. The first byte of each transfer holds a seven-bit target address and a direction bit. The target answers its own address, which is a fixed upper field joined to a lower field taken from strap pins. It also answers the all-targets (general call) address for writes.

Bytes written by the bus master reach the local logic on a valid/ready byte port. A flag marks the first byte after the address, and a second flag marks bytes that came through the general call. For reads, the target raises a request and the local logic answers with a byte on a valid port. The target pulls the clock line low to make the master wait while a received byte has not yet been taken, or while no byte to send has been supplied. The target changes the data line only a set number of internal cycles after it sees the clock go low, which keeps the data hold time.

The block only drives output enables. A high enable means the pin is pulled low; a low enable means the pin is left to the pull-up.

Top module: `i2c_target_stretch`

## Requirements
- R1: A START (data line falling while the clock line is high) begins address reception. A repeated START in the middle of a transfer starts address reception again without a STOP, and the new address decides the new direction.
- R2: The address byte is received MSB first: seven address bits, then a direction bit (0 = master writes, 1 = master reads). The target pulls data low during the 9th clock pulse only when the seven bits equal {FIXED_ADDR, addr_pins}. Changing addr_pins changes the address that is answered.
- R3: The address 7'h00 with direction 0 is acknowledged whatever the own address is, and the bytes that follow are delivered with rx_gcall = 1. The address 7'h00 with direction 1 is not acknowledged.
- R4: After an address that does not match, the target acknowledges nothing, drives neither line and delivers no byte until the next START.
- R5: A written byte is delivered on rx_data with rx_valid held, and rx_data stable, until rx_ready is high. rx_first is 1 only for the first byte after the address. If rx_decline is high when the 8th data bit ends, the byte is not acknowledged and not delivered, and the rest of the transfer is ignored.
- R6: If a received byte has not been taken by the end of its acknowledge pulse, the target holds the clock line low until rx_ready takes the byte. A consumer that is fast enough causes no stretch.
- R7: In a read, the target raises tx_req after each acknowledged pulse and holds the clock low until tx_valid is high. It then sends tx_data MSB first and releases the data line for the master's acknowledge pulse.
- R8: When the master does not acknowledge a read byte, the target releases the data line, raises no further tx_req and drives nothing until the next START or STOP.
- R9: The target's data-line enable never rises while the bus clock line is high, and it never changes across two cycles in which the clock line is high.
- R10: A STOP returns the target to idle. Clock pulses after a STOP and without a new START are ignored.
- R11: Under reset both line enables are low, and rx_valid and tx_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the bus clock line |
| sda_i | input | 1 | Level of the bus data line |
| scl_oe | output | 1 | Pull the clock line low (stretch) |
| sda_oe | output | 1 | Pull the data line low |
| addr_pins | input | STRAP_W | Lower, strap-selected address bits |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte is waiting |
| rx_first | output | 1 | Byte is the first after the address |
| rx_gcall | output | 1 | Byte arrived through the general call |
| rx_ready | input | 1 | Local side takes the waiting byte |
| rx_decline | input | 1 | Local side refuses the next byte |
| tx_req | output | 1 | Target needs a byte to send |
| tx_valid | input | 1 | tx_data holds the byte to send |
| tx_data | input | 8 | Byte to send to the master |

## Verification
Writes and reads go to the own address, to a re-strapped address, to a wrong address and to the general call address. This separates the fixed-plus-strap match from the all-targets match and from rejection. The local side answers either fast or slow, so the bench tells a transfer that needs no clock stretching from one where the clock is held. In both cases the byte values must come out the same. Directed cases cover a repeated START that changes direction or names a wrong target, a declined write, a master NACK followed by extra clocking, and clocking after a STOP with no START. Seeded random transfers of mixed direction, length and local latency then check byte integrity and the first-byte flag.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_ADDR,
        TS_WRITE,
        TS_READ,
        TS_WAIT
    } tgt_state_e;

    localparam int          BYTE_BITS  = 8;
    localparam int          FRAME_BITS = 9;
    localparam logic [6:0]  GCALL_ADDR = 7'h00;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] ff_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ff_q <= '1;
            end else begin
                ff_q <= {ff_q[STAGES-2:0], din[b]};
            end
        end
        assign dout[b] = ff_q[STAGES-1];
    end

endmodule

// File: rtl/i2c_tgt_events.sv
module i2c_tgt_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign scl_rise  = scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s & prev_q.scl;
    assign bus_start = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign bus_stop  = scl_s & prev_q.scl & ~prev_q.sda & sda_s;

endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
    import i2c_tgt_pkg::*;
#(
    parameter int                 STRAP_W    = 3,
    parameter logic [6-STRAP_W:0] FIXED_ADDR = '0
) (
    input  logic [7:0]         addr_byte,
    input  logic [STRAP_W-1:0] addr_pins,
    output logic               own_hit,
    output logic               gcall_hit
);

    logic [6:0] own_addr;

    assign own_addr  = {FIXED_ADDR, addr_pins};
    assign own_hit   = (addr_byte[7:1] == own_addr);
    assign gcall_hit = (addr_byte[7:1] == GCALL_ADDR) && !addr_byte[0];

endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
    import i2c_tgt_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       sda_s,
    input  logic       own_hit,
    input  logic       gcall_hit,
    output logic [7:0] shift_o,
    input  logic       rx_ready,
    input  logic       rx_decline,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_first,
    output logic       rx_gcall,
    output logic       tx_req
);

    localparam int                HOLD_W  = $clog2(HOLD_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LD = HOLD_W'(HOLD_CYC);
    localparam logic [HOLD_W-1:0] HOLD_1  = HOLD_W'(1);
    localparam logic [3:0]        LAST_D  = 4'(BYTE_BITS);
    localparam logic [3:0]        ACK_P   = 4'(FRAME_BITS);

    typedef struct packed {
        tgt_state_e        st;
        logic [3:0]        bitcnt;
        logic [7:0]        shreg;
        logic              mack;
        logic              first;
        logic              gcall;
        logic              sda_tgt;
        logic              sda_oe;
        logic [HOLD_W-1:0] hold;
        logic              scl_oe;
        logic              tx_req;
        logic [7:0]        rx_data;
        logic              rx_valid;
        logic              rx_first;
        logic              rx_gcall;
    } core_t;

    core_t d, q;
    logic  active;

    assign active = (q.st == TS_ADDR) || (q.st == TS_WRITE) || (q.st == TS_READ);

    always_comb begin
        d = q;

        // delayed application of a new data-line level (hold time)
        if (q.hold != '0) begin
            d.hold = q.hold - 1'b1;
            if (q.hold == HOLD_1) begin
                d.sda_oe = q.sda_tgt;
            end
        end

        if (q.rx_valid && rx_ready) begin
            d.rx_valid = 1'b0;
        end

        // byte to send supplied while the clock is held
        if (q.scl_oe && q.tx_req && tx_valid) begin
            d.tx_req  = 1'b0;
            d.shreg   = {tx_data[6:0], 1'b0};
            d.sda_tgt = ~tx_data[7];
            d.hold    = HOLD_LD;
        end

        if (q.scl_oe && !q.tx_req && !q.rx_valid && (q.hold == '0)) begin
            d.scl_oe = 1'b0;
        end

        if (bus_start || bus_stop) begin
            d.st      = bus_start ? TS_ADDR : TS_IDLE;
            d.bitcnt  = '0;
            d.first   = 1'b1;
            d.gcall   = 1'b0;
            d.scl_oe  = 1'b0;
            d.tx_req  = 1'b0;
            d.sda_oe  = 1'b0;
            d.sda_tgt = 1'b0;
            d.hold    = '0;
        end else if (active && scl_rise) begin
            if (q.bitcnt < ACK_P) begin
                d.bitcnt = q.bitcnt + 4'd1;
            end
            if ((q.bitcnt < LAST_D) && (q.st != TS_READ)) begin
                d.shreg = {q.shreg[6:0], sda_s};
            end
            if ((q.bitcnt == LAST_D) && (q.st == TS_READ)) begin
                d.mack = ~sda_s;
            end
        end else if (active && scl_fall) begin
            if (q.bitcnt == LAST_D) begin
                d.hold = HOLD_LD;
                unique case (q.st)
                    TS_ADDR: begin
                        if (own_hit || gcall_hit) begin
                            d.sda_tgt = 1'b1;
                            d.gcall   = gcall_hit;
                            d.mack    = 1'b1;
                            d.st      = (own_hit && q.shreg[0]) ? TS_READ : TS_WRITE;
                        end else begin
                            d.sda_tgt = 1'b0;
                            d.st      = TS_IDLE;
                        end
                    end
                    TS_WRITE: begin
                        if (rx_decline) begin
                            d.sda_tgt = 1'b0;
                            d.st      = TS_WAIT;
                        end else begin
                            d.sda_tgt  = 1'b1;
                            d.rx_data  = q.shreg;
                            d.rx_valid = 1'b1;
                            d.rx_first = q.first;
                            d.rx_gcall = q.gcall;
                            d.first    = 1'b0;
                        end
                    end
                    default: begin
                        d.sda_tgt = 1'b0;
                    end
                endcase
            end else if (q.bitcnt == ACK_P) begin
                d.bitcnt  = '0;
                d.sda_tgt = 1'b0;
                d.hold    = HOLD_LD;
                if (q.st == TS_WRITE) begin
                    if (q.rx_valid && !rx_ready) begin
                        d.scl_oe = 1'b1;
                    end
                end else if (q.st == TS_READ) begin
                    if (q.mack) begin
                        d.tx_req = 1'b1;
                        d.scl_oe = 1'b1;
                    end else begin
                        d.st = TS_WAIT;
                    end
                end
            end else if ((q.st == TS_READ) && (q.bitcnt != '0)) begin
                d.sda_tgt = ~q.shreg[7];
                d.shreg   = {q.shreg[6:0], 1'b0};
                d.hold    = HOLD_LD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= TS_IDLE;
            q.first <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign shift_o  = q.shreg;
    assign scl_oe   = q.scl_oe;
    assign sda_oe   = q.sda_oe;
    assign rx_data  = q.rx_data;
    assign rx_valid = q.rx_valid;
    assign rx_first = q.rx_first;
    assign rx_gcall = q.rx_gcall;
    assign tx_req   = q.tx_req;

endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch #(
    parameter int                 STRAP_W     = 3,
    parameter logic [6-STRAP_W:0] FIXED_ADDR  = 4'b1010,
    parameter int                 HOLD_CYC    = 4,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               scl_oe,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] addr_pins,
    output logic [7:0]         rx_data,
    output logic               rx_valid,
    output logic               rx_first,
    output logic               rx_gcall,
    input  logic               rx_ready,
    input  logic               rx_decline,
    output logic               tx_req,
    input  logic               tx_valid,
    input  logic [7:0]         tx_data
);

    logic [1:0] line_s;
    logic       scl_rise, scl_fall, bus_start, bus_stop;
    logic       own_hit, gcall_hit;
    logic [7:0] shift_byte;

    i2c_tgt_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (line_s)
    );

    i2c_tgt_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (line_s[1]),
        .sda_s     (line_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_tgt_match #(
        .STRAP_W    (STRAP_W),
        .FIXED_ADDR (FIXED_ADDR)
    ) u_match (
        .addr_byte (shift_byte),
        .addr_pins (addr_pins),
        .own_hit   (own_hit),
        .gcall_hit (gcall_hit)
    );

    i2c_tgt_core #(
        .HOLD_CYC (HOLD_CYC)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .sda_s      (line_s[0]),
        .own_hit    (own_hit),
        .gcall_hit  (gcall_hit),
        .shift_o    (shift_byte),
        .rx_ready   (rx_ready),
        .rx_decline (rx_decline),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_first   (rx_first),
        .rx_gcall   (rx_gcall),
        .tx_req     (tx_req)
    );

endmodule

// File: rtl/i2c_target_stretch_chk.sv
module i2c_target_stretch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic       tx_req,
    input logic       tx_valid
);

    // R9: the data-line enable only rises while the bus clock is low
    p_sda_rise_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R6 / R7: stretching starts only with a byte pending or requested
    p_stretch_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> (tx_req || rx_valid));

    // R7: stretching starts only while the clock is already low
    p_stretch_on_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !scl_i);

    // R5: a delivered byte stays put until taken
    p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R7: a byte request stays up until answered
    p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_valid) |=> tx_req);

endmodule

bind i2c_target_stretch i2c_target_stretch_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_req   (tx_req),
    .tx_valid (tx_valid)
);

// File: tb/i2c_target_stretch_tb_top.sv
module i2c_target_stretch_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam int         QT         = 20;
    localparam int         STRAP_W    = 3;
    localparam logic [3:0] FIXED      = 4'b1010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_bus, sda_bus, scl_oe, sda_oe;
    logic [STRAP_W-1:0] addr_pins = 3'b011;
    logic [7:0] rx_data;
    logic rx_valid, rx_first, rx_gcall, tx_req;
    logic rx_ready = 1'b0, rx_decline = 1'b0, tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_target_stretch dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_pins(addr_pins),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_gcall(rx_gcall), .rx_ready(rx_ready), .rx_decline(rx_decline),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data)
    );

    int n_chk = 0, n_err = 0;
    int rx_delay = 2, tx_delay = 2, rx_cnt = 0, tx_cnt = 0;
    int rx_n = 0, tx_idx = 0;
    int stretch_cnt = 0, hold_viol = 0, drive_cnt = 0, req_cnt = 0;
    logic [7:0] rxb [256];
    logic       rxf [256];
    logic       rxg [256];
    logic [7:0] txb [256];
    logic [7:0] wbuf [8];
    logic sda_prev = 1'b0, scl_prev = 1'b1;

    // local-side models and bus monitors
    always @(negedge clk) begin
        if (rx_ready) begin
            rx_ready = 1'b0;
        end else if (rx_valid) begin
            if (rx_cnt >= rx_delay) begin
                rxb[rx_n] = rx_data; rxf[rx_n] = rx_first; rxg[rx_n] = rx_gcall;
                rx_n++; rx_ready = 1'b1; rx_cnt = 0;
            end else rx_cnt++;
        end
        if (tx_valid && !tx_req) begin
            tx_valid = 1'b0; tx_idx++; tx_cnt = 0;
        end else if (tx_req && !tx_valid) begin
            if (tx_cnt >= tx_delay) begin
                tx_data = txb[tx_idx]; tx_valid = 1'b1;
            end else tx_cnt++;
        end
        if (scl_m && !scl_bus) stretch_cnt++;
        if (sda_oe) drive_cnt++;
        if (tx_req) req_cnt++;
        if ((sda_oe !== sda_prev) && scl_bus && scl_prev) hold_viol++;
        sda_prev = sda_oe; scl_prev = scl_bus;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        do @(negedge clk); while (!scl_bus);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wait_cyc(QT);
        scl_m = 1'b1; wait_scl_high(); wait_cyc(QT);
        sda_m = 1'b0; wait_cyc(QT);
        scl_m = 1'b0; wait_cyc(QT);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wait_cyc(QT);
        scl_m = 1'b1; wait_scl_high(); wait_cyc(QT);
        sda_m = 1'b1; wait_cyc(QT);
    endtask

    task automatic m_bit(input logic b, output logic r);
        sda_m = b; wait_cyc(QT);
        scl_m = 1'b1; wait_scl_high(); wait_cyc(QT);
        r = sda_bus; wait_cyc(QT);
        scl_m = 1'b0; wait_cyc(QT);
    endtask

    task automatic m_wbyte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(b[i], r);
        m_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic m_rbyte(input logic ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); b[i] = r; end
        m_bit(~ack, r);
    endtask

    function automatic logic [6:0] own7(input logic [STRAP_W-1:0] p);
        return {FIXED, p};
    endfunction

    // write transfer; returns address ack and number of acked data bytes
    task automatic m_wtxn(input logic [6:0] a, input int n, input logic do_stop,
                          output logic aack, output int dacks);
        logic ak;
        m_start();
        m_wbyte({a, 1'b0}, aack);
        dacks = 0;
        for (int k = 0; k < n; k++) begin
            wbuf[k] = 8'($urandom);
            m_wbyte(wbuf[k], ak);
            if (ak) dacks++;
        end
        if (do_stop) m_stop();
    endtask

    // read transfer; counts bytes differing from the supplied ones
    task automatic m_rtxn(input logic [6:0] a, input int n, output logic aack, output int mism);
        logic [7:0] b;
        int base;
        base = tx_idx; mism = 0;
        m_start();
        m_wbyte({a, 1'b1}, aack);
        if (aack) begin
            for (int k = 0; k < n; k++) begin
                m_rbyte(k != n - 1, b);
                if (b !== txb[base + k]) mism++;
            end
        end
        m_stop();
    endtask

    task automatic rx_compare(input string req, input int base, input int n, input logic g);
        int mm;
        mm = 0;
        for (int k = 0; k < n; k++) begin
            if (rxb[base + k] !== wbuf[k]) mm++;
            if (rxf[base + k] !== (k == 0)) mm++;
            if (rxg[base + k] !== g) mm++;
        end
        chk(req, "received byte/flag mismatches", mm, 0);
    endtask

    initial begin
        logic aack;
        int   da, mm, base, s0, r0, t0;
        logic [7:0] b;
        void'($urandom(32'h5eed));
        for (int i = 0; i < 256; i++) txb[i] = 8'($urandom);
        wait_cyc(4);
        // R11: reset state
        chk("R11", "outputs in reset", {scl_oe, sda_oe, rx_valid, tx_req}, 0);
        rst_n = 1'b1; wait_cyc(5);

        // R2 / R5 / R6: own address write, fast consumer, no stretch
        base = rx_n; stretch_cnt = 0;
        m_wtxn(own7(addr_pins), 3, 1'b1, aack, da);
        chk("R2", "own address ack", aack, 1);
        chk("R5", "data acks", da, 3);
        chk("R5", "bytes delivered", rx_n - base, 3);
        rx_compare("R5", base, 3, 1'b0);
        chk("R6", "stretch cycles with fast consumer", stretch_cnt, 0);

        // R6: slow consumer stretches the clock
        rx_delay = 200; base = rx_n; stretch_cnt = 0;
        m_wtxn(own7(addr_pins), 2, 1'b1, aack, da);
        chk("R6", "slow consumer causes stretch", stretch_cnt > 0, 1);
        rx_compare("R6", base, 2, 1'b0);
        rx_delay = 2;

        // R2: re-strapped address
        addr_pins = 3'b101; base = rx_n;
        m_wtxn(own7(3'b101), 1, 1'b1, aack, da);
        chk("R2", "strapped address ack", aack, 1);
        rx_compare("R2", base, 1, 1'b0);

        // R4: wrong address ignored
        base = rx_n; drive_cnt = 0;
        m_wtxn(own7(3'b011), 2, 1'b1, aack, da);
        chk("R4", "wrong address ack", aack, 0);
        chk("R4", "data acks after mismatch", da, 0);
        chk("R4", "bytes delivered after mismatch", rx_n - base, 0);
        chk("R4", "data line driven cycles", drive_cnt, 0);

        // R3: general call write accepted, read refused
        base = rx_n;
        m_wtxn(7'h00, 2, 1'b1, aack, da);
        chk("R3", "general call ack", aack, 1);
        rx_compare("R3", base, 2, 1'b1);
        t0 = tx_idx;
        m_rtxn(7'h00, 1, aack, mm);
        chk("R3", "general call read ack", aack, 0);
        chk("R3", "no byte taken on general read", tx_idx - t0, 0);

        // R7: read with slow supplier
        tx_delay = 200; stretch_cnt = 0; t0 = tx_idx;
        m_rtxn(own7(addr_pins), 3, aack, mm);
        chk("R7", "read address ack", aack, 1);
        chk("R7", "read byte mismatches", mm, 0);
        chk("R7", "read stretch seen", stretch_cnt > 0, 1);
        chk("R7", "bytes supplied", tx_idx - t0, 3);
        tx_delay = 2;

        // R8: master NACK, then extra clocking
        t0 = tx_idx;
        m_start();
        m_wbyte({own7(addr_pins), 1'b1}, aack);
        m_rbyte(1'b0, b);
        chk("R8", "byte before NACK", b, txb[t0]);
        req_cnt = 0; drive_cnt = 0;
        m_rbyte(1'b0, b);
        chk("R8", "released line after NACK", b, 8'hff);
        chk("R8", "requests after NACK", req_cnt, 0);
        chk("R8", "drive after NACK", drive_cnt, 0);
        m_stop();

        // R1: repeated START changes direction
        base = rx_n; t0 = tx_idx;
        m_wtxn(own7(addr_pins), 1, 1'b0, aack, da);
        rx_compare("R1", base, 1, 1'b0);
        m_rtxn(own7(addr_pins), 2, aack, mm);
        chk("R1", "read after repeated start ack", aack, 1);
        chk("R1", "read after repeated start data", mm, 0);
        // R1: repeated START naming another target
        m_wtxn(own7(addr_pins), 1, 1'b0, aack, da);
        base = rx_n;
        m_wtxn(own7(3'b000), 1, 1'b1, aack, da);
        chk("R1", "wrong address after repeated start", {aack, da[0]}, 0);
        chk("R1", "nothing delivered after wrong restart", rx_n - base, 0);

        // R5: declined byte
        base = rx_n;
        m_start();
        m_wbyte({own7(addr_pins), 1'b0}, aack);
        rx_decline = 1'b1;
        m_wbyte(8'h3c, aack);
        chk("R5", "declined byte ack", aack, 0);
        rx_decline = 1'b0;
        m_wbyte(8'hc3, aack);
        chk("R5", "byte after decline ack", aack, 0);
        chk("R5", "declined bytes delivered", rx_n - base, 0);
        m_stop();

        // R10: clocking after STOP without START
        base = rx_n;
        scl_m = 1'b0; wait_cyc(QT);
        m_wbyte({own7(addr_pins), 1'b0}, aack);
        chk("R10", "ack without START", aack, 0);
        m_wbyte(8'h55, aack);
        chk("R10", "bytes without START", rx_n - base, 0);
        m_stop();

        // random mixed transfers (R5, R7)
        for (int t = 0; t < 12; t++) begin
            int n;
            n = 1 + int'($urandom % 4);
            rx_delay = int'($urandom % 150);
            tx_delay = int'($urandom % 150);
            if ($urandom % 2 == 0) begin
                base = rx_n;
                m_wtxn(own7(addr_pins), n, 1'b1, aack, da);
                chk("R5", "random write acks", {aack, da}, {1'b1, n});
                rx_compare("R5", base, n, 1'b0);
            end else begin
                s0 = tx_idx;
                m_rtxn(own7(addr_pins), n, aack, mm);
                chk("R7", "random read data", {aack, mm}, {1'b1, 32'd0});
                chk("R7", "random read count", tx_idx - s0, n);
            end
        end
        r0 = hold_viol;
        chk("R9", "data changes while clock high", r0, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule